// File: doc/BRIEF.md
# Field delay reset sequencer

This controller drives the reset and enable pins of a dual-port field memory so that the memory behaves as a fixed digital delay line. It runs from one clock shared with both memory ports. After reset release it stays quiet for a stabilisation interval. It then runs dummy write and dummy read cycles together. After that it enters a periodic schedule. In that schedule a write reset recurs once per field and a read reset follows each write reset after a programmed offset. The offset sets the delay through the memory.

The field length and the offset are configuration inputs. They are captured once, on the last cycle of the stabilisation interval. If that setting would break a memory rule, the sequencer raises a sticky error flag and keeps every memory pin low until the next reset. The rules are a run shorter than the required minimum, an offset in the window where returned data is unpredictable, and an offset that does not fit inside the field. An offset below the old-data limit reads back the previous field. An offset at or above the new-data limit reads back the field just written.

Top module: `field_delay_seq`

## Requirements
- R1: While rst_ni is low, and for STAB_CYC cycles after its release, every output is low.
- R2: For the DUMMY_CYC cycles after the stabilisation interval, wr_en_o and rd_en_o are both high, and wr_rst_o, rd_rst_o and cfg_err_o are low.
- R3: From the first cycle after the dummy cycles, wr_rst_o is a one-cycle pulse that repeats every captured field length.
- R4: rd_rst_o is a one-cycle pulse issued exactly offset cycles after each wr_rst_o pulse, in the same cycle when the offset is 0, and with the same period as wr_rst_o.
- R5: In the periodic schedule, each enable is low only during its own reset cycle and high in every other cycle. Each run between resets therefore has field length minus 1 active cycles.
- R6: A field length below MIN_RUN+1 is illegal.
- R7: An offset with OLD_MAX <= offset < NEW_MIN is illegal. An offset below OLD_MAX (old field read back) or at or above NEW_MIN (new field read back) is legal.
- R8: An offset greater than or equal to the field length is illegal.
- R9: An illegal setting drives cfg_err_o high from the end of the stabilisation interval, with all other outputs low, until rst_ni. The configuration is captured only on the last stabilisation cycle, and later changes to the inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with both memory ports |
| rst_ni | input | 1 | Active-low asynchronous reset |
| field_len_i | input | LW | Field length in cycles, the write reset period |
| offset_i | input | LW | Read reset delay after each write reset |
| wr_rst_o | output | 1 | Write address reset pulse to the memory |
| rd_rst_o | output | 1 | Read address reset pulse to the memory |
| wr_en_o | output | 1 | Write enable to the memory |
| rd_en_o | output | 1 | Read enable to the memory |
| cfg_err_o | output | 1 | Sticky illegal-configuration flag |

## Verification
The bench builds the block with STAB_CYC=20, DUMMY_CYC=8, MIN_RUN=8, OLD_MAX=7 and NEW_MIN=60. With these values the power-up phases take a few dozen cycles, and both legal offset regions and the forbidden window fit inside fields of 9 to 100 cycles. That brings within reach the minimum field length on both sides, the offsets 0, 6, 7, 59 and 60, an offset equal to the field length, and a configuration change after capture. A behavioural model, driven only by the count of cycles since reset, predicts every output and is compared against the design on every cycle.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  typedef enum logic [1:0] {
    ST_STAB  = 2'd0,
    ST_DUMMY = 2'd1,
    ST_RUN   = 2'd2,
    ST_ERR   = 2'd3
  } fdr_state_e;
endpackage

// File: rtl/fdr_tick_cnt.sv
module fdr_tick_cnt #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          last_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + TW'(1);
  end

  assign last_o = en_i && (cnt_q == limit_i - TW'(1));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < limit_i)); // R2
endmodule

// File: rtl/fdr_cfg_check.sv
module fdr_cfg_check #(
  parameter int LW      = 16,
  parameter int MIN_RUN = 80,
  parameter int OLD_MAX = 70,
  parameter int NEW_MIN = 600
) (
  input  logic [LW-1:0] len_i,
  input  logic [LW-1:0] off_i,
  output logic          legal_o
);
  localparam logic [LW-1:0] MinLen = LW'(MIN_RUN + 1);
  localparam logic [LW-1:0] OldLim = LW'(OLD_MAX);
  localparam logic [LW-1:0] NewLim = LW'(NEW_MIN);

  logic len_ok, fit_ok, win_ok;

  always_comb begin
    len_ok  = (len_i >= MinLen);
    fit_ok  = (off_i < len_i);
    win_ok  = (off_i < OldLim) || (off_i >= NewLim);
    legal_o = len_ok && fit_ok && win_ok;
  end
endmodule

// File: rtl/fdr_phase_gen.sv
module fdr_phase_gen #(
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [LW-1:0] len_i,
  input  logic [LW-1:0] off_i,
  output logic          wr_rst_o,
  output logic          rd_rst_o,
  output logic          wr_en_o,
  output logic          rd_en_o
);
  logic [LW-1:0] ph_q;
  logic          ph_wrap;

  assign ph_wrap = (ph_q == len_i - LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (!run_i)  ph_q <= '0;
    else if (ph_wrap) ph_q <= '0;
    else              ph_q <= ph_q + LW'(1);
  end

  always_comb begin
    wr_rst_o = run_i && (ph_q == '0);
    rd_rst_o = run_i && (ph_q == off_i);
    wr_en_o  = run_i && !wr_rst_o;
    rd_en_o  = run_i && !rd_rst_o;
  end

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (ph_q < len_i)); // R3
  AST_WR_RST_GAP1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_rst_o) |-> !wr_rst_o); // R3
  AST_WR_RST_GAP2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_rst_o, 2) |-> !wr_rst_o); // R3
  AST_RD_RST_GAP1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_rst_o) |-> !rd_rst_o); // R4
  AST_RD_RST_GAP2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_rst_o, 2) |-> !rd_rst_o); // R4
endmodule

// File: rtl/field_delay_seq.sv
module field_delay_seq #(
  parameter int LW        = 16,
  parameter int STAB_CYC  = 10_000_000,
  parameter int DUMMY_CYC = 80,
  parameter int MIN_RUN   = 80,
  parameter int OLD_MAX   = 70,
  parameter int NEW_MIN   = 600
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] field_len_i,
  input  logic [LW-1:0] offset_i,
  output logic          wr_rst_o,
  output logic          rd_rst_o,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic          cfg_err_o
);
  import fdr_pkg::*;

  localparam int TMax = (STAB_CYC > DUMMY_CYC) ? STAB_CYC : DUMMY_CYC;
  localparam int TW   = $clog2(TMax + 1);

  fdr_state_e    state_q, state_d;
  logic [LW-1:0] len_q, off_q;
  logic          tick_last, tick_en, cfg_legal, run;
  logic [TW-1:0] tick_limit;
  logic          pg_wr_rst, pg_rd_rst, pg_wr_en, pg_rd_en;

  assign tick_en    = (state_q == ST_STAB) || (state_q == ST_DUMMY);
  assign tick_limit = (state_q == ST_STAB) ? TW'(STAB_CYC) : TW'(DUMMY_CYC);

  fdr_tick_cnt #(.TW(TW)) i_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tick_en),
    .clr_i   (state_q != state_d),
    .limit_i (tick_limit),
    .last_o  (tick_last)
  );

  fdr_cfg_check #(
    .LW(LW), .MIN_RUN(MIN_RUN), .OLD_MAX(OLD_MAX), .NEW_MIN(NEW_MIN)
  ) i_cfg (
    .len_i   (field_len_i),
    .off_i   (offset_i),
    .legal_o (cfg_legal)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_STAB:  if (tick_last) state_d = cfg_legal ? ST_DUMMY : ST_ERR;
      ST_DUMMY: if (tick_last) state_d = ST_RUN;
      ST_RUN:   state_d = ST_RUN;
      ST_ERR:   state_d = ST_ERR;
      default:  state_d = ST_ERR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STAB;
      len_q   <= '0;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_STAB && tick_last) begin
        len_q <= field_len_i;
        off_q <= offset_i;
      end
    end
  end

  assign run = (state_q == ST_RUN);

  fdr_phase_gen #(.LW(LW)) i_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .len_i    (len_q),
    .off_i    (off_q),
    .wr_rst_o (pg_wr_rst),
    .rd_rst_o (pg_rd_rst),
    .wr_en_o  (pg_wr_en),
    .rd_en_o  (pg_rd_en)
  );

  always_comb begin
    wr_rst_o  = pg_wr_rst;
    rd_rst_o  = pg_rd_rst;
    wr_en_o   = (state_q == ST_DUMMY) || pg_wr_en;
    rd_en_o   = (state_q == ST_DUMMY) || pg_rd_en;
    cfg_err_o = (state_q == ST_ERR);
  end

  // active-cycle counters since the last reset, for the run-length checks
  logic [LW:0] wr_run_q, rd_run_q;
  logic        wr_seen_q, rd_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_run_q <= '0; rd_run_q <= '0; wr_seen_q <= 1'b0; rd_seen_q <= 1'b0;
    end else begin
      if (wr_rst_o) begin wr_run_q <= '0; wr_seen_q <= 1'b1; end
      else if (wr_en_o && !(&wr_run_q)) wr_run_q <= wr_run_q + 1'b1;
      if (rd_rst_o) begin rd_run_q <= '0; rd_seen_q <= 1'b1; end
      else if (rd_en_o && !(&rd_run_q)) rd_run_q <= rd_run_q + 1'b1;
    end
  end

  AST_WR_RUN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rst_o && wr_seen_q) |-> (wr_run_q >= (LW+1)'(MIN_RUN))); // R5
  AST_RD_RUN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rst_o && rd_seen_q) |-> (rd_run_q >= (LW+1)'(MIN_RUN))); // R5
  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !(wr_rst_o || rd_rst_o || wr_en_o || rd_en_o)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o); // R9
  AST_RUN_CFG_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (off_q < len_q)); // R8
  AST_RUN_CFG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run) |-> ($stable(len_q) && $stable(off_q))); // R9
endmodule

// File: tb/test_field_delay_seq.sv
module test_field_delay_seq;
  localparam int LW = 16, STAB = 20, DUM = 8, MINR = 8, OLDM = 7, NEWM = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LW-1:0] len_i = '0, off_i = '0;
  logic wr_rst, rd_rst, wr_en, rd_en, err;
  int   checks = 0, errors = 0, k = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  field_delay_seq #(
    .LW(LW), .STAB_CYC(STAB), .DUMMY_CYC(DUM), .MIN_RUN(MINR),
    .OLD_MAX(OLDM), .NEW_MIN(NEWM)
  ) i_field_delay_seq (
    .clk_i(clk), .rst_ni(rst_n), .field_len_i(len_i), .offset_i(off_i),
    .wr_rst_o(wr_rst), .rd_rst_o(rd_rst), .wr_en_o(wr_en), .rd_en_o(rd_en),
    .cfg_err_o(err)
  );

  always @(posedge clk) k <= rst_n ? k + 1 : 0;

  function automatic bit legal_cfg(int l, int o);
    return (l >= MINR + 1) && (o < l) && ((o < OLDM) || (o >= NEWM));
  endfunction

  task automatic chk(bit act, bit exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s k=%0d actual=%0b expected=%0b", tag, what, k, act, exp);
    end
  endtask

  // behavioural expectation from cycles since reset release
  task automatic compare(int l, int o, string etag);
    bit lg, stab, dum, run, ewr, erd, ewe, ere, eer;
    int ph;
    string t;
    lg   = legal_cfg(l, o);
    stab = (k < STAB);
    dum  = lg && !stab && (k < STAB + DUM);
    run  = lg && (k >= STAB + DUM);
    ph   = run ? (k - STAB - DUM) % l : -1;
    ewr  = run && ph == 0;
    erd  = run && ph == o;
    ewe  = dum || (run && ph != 0);
    ere  = dum || (run && ph != o);
    eer  = !lg && !stab;
    t = stab ? "R1" : (!lg ? etag : (dum ? "R2" : ""));
    chk(wr_rst, ewr, (t != "") ? t : "R3", "wr_rst");
    chk(rd_rst, erd, (t != "") ? t : "R4", "rd_rst");
    chk(wr_en,  ewe, (t != "") ? t : "R5", "wr_en");
    chk(rd_en,  ere, (t != "") ? t : "R5", "rd_en");
    chk(err,    eer, (t != "") ? t : "R9", "cfg_err");
  endtask

  task automatic run_case(int l, int o, int ncyc, string etag, bit chg);
    rst_n = 1'b0;
    len_i = LW'(l);
    off_i = LW'(o);
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(wr_rst | rd_rst | wr_en | rd_en | err, 1'b0, "R1", "outputs_in_reset");
    rst_n = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      compare(l, o, etag);
      if (chg && k == STAB + 3) begin
        len_i = LW'(8);  // R9: post-capture change must be ignored
        off_i = LW'(30);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk);
    run_case(20, 3, 120, "R7", 1'b0);    // old-data offset
    run_case(100, 60, 330, "R7", 1'b0);  // new-data offset at lower bound
    run_case(20, 0, 90, "R4", 1'b0);     // read reset with write reset
    run_case(9, 6, 80, "R6", 1'b0);      // minimum legal length
    run_case(8, 2, 50, "R6", 1'b0);      // R6 too short
    run_case(100, 7, 50, "R7", 1'b0);    // R7 window low edge
    run_case(100, 59, 50, "R7", 1'b0);   // R7 window high edge
    run_case(70, 70, 50, "R8", 1'b0);    // R8 offset equals length
    run_case(20, 5, 120, "R9", 1'b1);    // R9 change after capture
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule